// File: doc/BRIEF.md
# Byte-wide SPI master peripheral with host register file

This block is an SPI master that a processor drives through a small register file on a simple single-cycle host bus. Software sets the clock polarity, phase and bit order in the first control register, chooses the serial clock rate through a prescaler field and a power-of-two field, and starts a transfer by writing one byte to the data register. The byte is shifted out on MOSI while MISO is shifted into the same data register, whose read side returns the received byte once the transfer completes.

Three sticky flags report progress: transfer complete, write collision (data written while a byte was still in flight) and mode fault (another master pulled the slave-select input low). An interrupt output combines completion and mode fault under an enable bit. The slave-select output and the pad output enables come straight from a port-data and a port-direction register, so software frames each message itself.

The host bus is plain: a write or read is one cycle with `bus_wr` or `bus_rd` high, always accepted, never stalled; read data is combinational in that cycle and read side effects take place at its closing clock edge. There is no streaming interface, so no back-pressure applies.

Top module: `spi_master_periph`

## Requirements
- R1: After reset every register reads 0x00, the serial clock sits low, no flag is set and the interrupt output is low.
- R2: Registers sit at these offsets: control-1 0x00, control-2 0x01, rate 0x04, status 0x05, data 0x09, port data 0x0D, port direction 0x10; unused offsets read 0x00; the rate register keeps only bits 6:4 and 2:0, the other bits read 0.
- R3: With rate prescaler field P (bits 6:4) and power field S (bits 2:0), each serial-clock half period lasts (P+1)*2^S bus clocks, so the SCK period is (P+1)*2^(S+1) bus clocks, at least 2.
- R4: While idle the serial clock rests at the polarity bit (control-1 bit 3); a byte produces exactly 16 clock edges and leaves the clock at its rest level.
- R5: With phase bit (control-1 bit 2) at 0 the first data bit appears on MOSI the cycle after the data write and MISO is sampled on leading edges; with phase 1 MOSI changes on leading edges and MISO is sampled on trailing edges; control-1 bit 0 set sends and receives bit 0 first, clear sends bit 7 first.
- R6: A data-register write starts a transfer only when enable (control-1 bit 6) and master (control-1 bit 4) are both set; otherwise it is ignored.
- R7: A data write during a transfer sets the collision flag (status bit 6), is discarded, and leaves the running transfer unchanged.
- R8: The completion flag (status bit 7) rises two cycles after the last clock edge, with the received byte readable at the data offset; it clears only when a status read that saw it set is followed by a data read.
- R9: The collision flag clears by the same status-read-then-data-read sequence.
- R10: When enable and master are set, port-direction bit 3 is 0 and the slave-select input is low, the mode-fault flag (status bit 4) sets; a status read that saw it, followed by a control-1 write, clears it.
- R11: The interrupt output is high exactly when control-1 bit 7 is set and the completion or mode-fault flag is set.
- R12: The slave-select output follows port-data bit 3; port-direction bits 1, 2 and 3 drive the MOSI, SCK and slave-select output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, else 0 |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out output enable |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Slave select out, active low |
| ss_oe | output | 1 | Slave select output enable |
| ss_n_i | input | 1 | Slave select sense, active low |

## Verification
The assertions take for granted that read and write strobes never share a cycle, that the rate register is not rewritten while a byte is shifting, and that the slave-select sense input is already synchronous to the bus clock. The stimulus issues one bus operation at a time with an idle cycle between, changes the rate only between transfers, and drives the sense input and MISO from the falling clock edge so both are stable at every rising edge.

// File: rtl/spi_periph_pkg.sv
package spi_periph_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL_A = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL_B = 5'h01;
  localparam logic [ADDR_W-1:0] OFS_RATE   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_FLAGS  = 5'h05;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h09;
  localparam logic [ADDR_W-1:0] OFS_PDATA  = 5'h0D;
  localparam logic [ADDR_W-1:0] OFS_PDIR   = 5'h10;

  localparam int B_IRQ_EN  = 7;
  localparam int B_ENABLE  = 6;
  localparam int B_MASTER  = 4;
  localparam int B_POL     = 3;
  localparam int B_PHA     = 2;
  localparam int B_LSB     = 0;

  localparam int F_DONE    = 7;
  localparam int F_COLL    = 6;
  localparam int F_FAULT   = 4;

  localparam int P_MOSI    = 1;
  localparam int P_SCK     = 2;
  localparam int P_SEL     = 3;

  localparam logic [REG_W-1:0] RATE_MASK = 8'h77;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int PRE_W = 3,
  parameter int POW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [POW_W-1:0] pow,
  output logic             tick
);
  localparam int HALF_W = PRE_W + (1 << POW_W);

  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt_q;

  assign half = (HALF_W'(pre) + HALF_W'(1)) << pow;
  assign tick = run && (cnt_q == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + HALF_W'(1);
  end

  // R3: the half-period counter never runs past its terminal count
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(pre) && $stable(pow)) |-> (cnt_q < half));
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tick,
  input  logic         miso,
  output logic         busy,
  output logic         sck,
  output logic         mosi,
  output logic         last_edge,
  output logic         done,
  output logic [W-1:0] rx_data
);
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);
  localparam int KW    = EW - 1;

  logic [EW-1:0] ecnt_q;
  logic [KW-1:0] k;
  logic [W-1:0]  tx_q;
  logic          sample_now;

  function automatic logic [KW-1:0] slot(input logic [KW-1:0] i, input logic lsb);
    return lsb ? i : KW'(W - 1) - i;
  endfunction

  assign k          = ecnt_q[EW-1:1];
  assign sample_now = (ecnt_q[0] == cpha);
  assign last_edge  = busy && tick && (ecnt_q == EW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      ecnt_q  <= '0;
      tx_q    <= '0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        busy   <= 1'b0;
        sck    <= cpol;
        ecnt_q <= '0;
      end else if (!busy) begin
        sck <= cpol;
        if (load) begin
          busy   <= 1'b1;
          tx_q   <= load_data;
          ecnt_q <= '0;
          if (!cpha) mosi <= load_data[slot('0, lsb_first)];
        end
      end else if (tick) begin
        sck    <= ~sck;
        ecnt_q <= ecnt_q + EW'(1);
        if (sample_now) rx_data[slot(k, lsb_first)] <= miso;
        if (!cpha && ecnt_q[0] && (k != KW'(W - 1)))
          mosi <= tx_q[slot(k + KW'(1), lsb_first)];
        if (cpha && !ecnt_q[0])
          mosi <= tx_q[slot(k, lsb_first)];
        if (last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4: between transfers the clock rests at the polarity level
  assert_sck_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol) && $past(enable)) |-> (sck == cpol));

  // R4: a finished byte leaves the clock at its rest level
  assert_sck_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && $stable(cpol)) |=> (sck == cpol));
endmodule

// File: rtl/spi_master_periph.sv
module spi_master_periph
  import spi_periph_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              ss_n_o,
  output logic              ss_oe,
  input  logic              ss_n_i
);
  localparam int PRE_W = 3;
  localparam int POW_W = 3;

  logic [REG_W-1:0] ctrl_a_q, ctrl_b_q, rate_q, pdata_q, pdir_q, rxbuf_q;
  logic             done_f_q, coll_f_q, fault_f_q;
  logic             arm_done_q, arm_coll_q, arm_fault_q;

  logic wr_ctrl_a, wr_data, rd_flags, rd_data;
  logic active, start, collide, fault_seen;
  logic tick, busy, last_edge, xfer_done;
  logic [REG_W-1:0] rx_byte, flags_view;

  assign wr_ctrl_a = bus_wr && (bus_addr == OFS_CTRL_A);
  assign wr_data   = bus_wr && (bus_addr == OFS_DATA);
  assign rd_flags  = bus_rd && (bus_addr == OFS_FLAGS);
  assign rd_data   = bus_rd && (bus_addr == OFS_DATA);

  assign active     = ctrl_a_q[B_ENABLE] && ctrl_a_q[B_MASTER];
  assign start      = wr_data && active && !busy;
  assign collide    = wr_data && active && busy;
  assign fault_seen = active && !pdir_q[P_SEL] && !ss_n_i;

  spi_rate_gen #(.PRE_W(PRE_W), .POW_W(POW_W)) i_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .pre  (rate_q[6:4]),
    .pow  (rate_q[2:0]),
    .tick (tick)
  );

  spi_shift_core #(.W(REG_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (active),
    .cpol     (ctrl_a_q[B_POL]),
    .cpha     (ctrl_a_q[B_PHA]),
    .lsb_first(ctrl_a_q[B_LSB]),
    .load     (start),
    .load_data(bus_wdata),
    .tick     (tick),
    .miso     (miso_i),
    .busy     (busy),
    .sck      (sck_o),
    .mosi     (mosi_o),
    .last_edge(last_edge),
    .done     (xfer_done),
    .rx_data  (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      rate_q   <= '0;
      pdata_q  <= '0;
      pdir_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL_A: ctrl_a_q <= bus_wdata;
        OFS_CTRL_B: ctrl_b_q <= bus_wdata;
        OFS_RATE:   rate_q   <= bus_wdata & RATE_MASK;
        OFS_PDATA:  pdata_q  <= bus_wdata;
        OFS_PDIR:   pdir_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q     <= '0;
      done_f_q    <= 1'b0;
      coll_f_q    <= 1'b0;
      fault_f_q   <= 1'b0;
      arm_done_q  <= 1'b0;
      arm_coll_q  <= 1'b0;
      arm_fault_q <= 1'b0;
    end else begin
      if (xfer_done) rxbuf_q <= rx_byte;

      if (xfer_done)                   done_f_q <= 1'b1;
      else if (rd_data && arm_done_q)  done_f_q <= 1'b0;

      if (collide)                     coll_f_q <= 1'b1;
      else if (rd_data && arm_coll_q)  coll_f_q <= 1'b0;

      if (fault_seen)                     fault_f_q <= 1'b1;
      else if (wr_ctrl_a && arm_fault_q)  fault_f_q <= 1'b0;

      if (rd_flags) begin
        arm_done_q <= done_f_q;
        arm_coll_q <= coll_f_q;
      end else if (rd_data) begin
        arm_done_q <= 1'b0;
        arm_coll_q <= 1'b0;
      end

      if (rd_flags)       arm_fault_q <= fault_f_q;
      else if (wr_ctrl_a) arm_fault_q <= 1'b0;
    end
  end

  always_comb begin
    flags_view          = '0;
    flags_view[F_DONE]  = done_f_q;
    flags_view[F_COLL]  = coll_f_q;
    flags_view[F_FAULT] = fault_f_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL_A: bus_rdata = ctrl_a_q;
        OFS_CTRL_B: bus_rdata = ctrl_b_q;
        OFS_RATE:   bus_rdata = rate_q;
        OFS_FLAGS:  bus_rdata = flags_view;
        OFS_DATA:   bus_rdata = rxbuf_q;
        OFS_PDATA:  bus_rdata = pdata_q;
        OFS_PDIR:   bus_rdata = pdir_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_o   = ctrl_a_q[B_IRQ_EN] && (done_f_q || fault_f_q);
  assign ss_n_o  = pdata_q[P_SEL];
  assign ss_oe   = pdir_q[P_SEL];
  assign sck_oe  = pdir_q[P_SCK];
  assign mosi_oe = pdir_q[P_MOSI];

  // R7: a colliding write leaves the running byte in flight
  assert_coll_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !last_edge) |=> busy);

  // R7: a colliding write always raises the collision flag
  assert_coll_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> coll_f_q);

  // R8: completion stays set until a data read
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f_q && !rd_data) |=> done_f_q);

  // R10: a mode fault only rises from an active master sensing select low
  assert_fault_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_f_q) |-> $past(active && !pdir_q[P_SEL] && !ss_n_i));

  // R6: no transfer begins while the peripheral is not an enabled master
  assert_start_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !busy) |=> !busy);
endmodule

// File: tb/test_spi_master_periph.sv
module test_spi_master_periph;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] b_addr = '0;
  logic       b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0] b_wdata = '0;
  logic [7:0] rdata;
  logic       irq, sck, sck_oe, mosi, mosi_oe, ss_n, ss_oe;
  logic       miso = 1'b0, ss_in = 1'b1;

  int total = 0, bad = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  spi_master_periph i_spi_master_periph (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .irq_o(irq), .sck_o(sck),
    .sck_oe(sck_oe), .mosi_o(mosi), .mosi_oe(mosi_oe), .miso_i(miso),
    .ss_n_o(ss_n), .ss_oe(ss_oe), .ss_n_i(ss_in)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_c1, m_c2, m_rate, m_pd, m_pdir, m_rxbuf, m_tx, m_rx;
  bit m_spif, m_wcol, m_modf, m_as, m_aw, m_am, m_busy, m_sck, m_mosi, m_done;
  int m_cnt, m_edge;

  function automatic bit pick(input logic [7:0] d, input int i, input bit lsb);
    return lsb ? d[i] : d[7-i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = 0; m_c2 = 0; m_rate = 0; m_pd = 0; m_pdir = 0; m_rxbuf = 0;
      m_tx = 0; m_rx = 0; m_spif = 0; m_wcol = 0; m_modf = 0;
      m_as = 0; m_aw = 0; m_am = 0; m_busy = 0; m_sck = 0; m_mosi = 0;
      m_done = 0; m_cnt = 0; m_edge = 0;
    end else begin
      bit en, pol, pha, lsb, wd, rs, rdd, wc1, tk, ob, nd, ospif, owcol, omodf;
      int half;
      en  = m_c1[6] & m_c1[4];
      pol = m_c1[3]; pha = m_c1[2]; lsb = m_c1[0];
      half = ((m_rate >> 4) % 8 + 1) << (m_rate % 8);
      wd  = b_wr && b_addr == 5'h09;
      wc1 = b_wr && b_addr == 5'h00;
      rs  = b_rd && b_addr == 5'h05;
      rdd = b_rd && b_addr == 5'h09;
      ob  = m_busy;
      tk  = ob && (m_cnt == half - 1);
      ospif = m_spif; owcol = m_wcol; omodf = m_modf;
      // flags
      if (m_done) m_rxbuf = m_rx;
      if (m_done) m_spif = 1; else if (rdd && m_as) m_spif = 0;
      if (wd && en && ob) m_wcol = 1; else if (rdd && m_aw) m_wcol = 0;
      if (en && !m_pdir[3] && !ss_in) m_modf = 1; else if (wc1 && m_am) m_modf = 0;
      if (rs) begin m_as = ospif; m_aw = owcol; end
      else if (rdd) begin m_as = 0; m_aw = 0; end
      if (rs) m_am = omodf; else if (wc1) m_am = 0;
      // rate counter
      m_cnt = (!ob || tk) ? 0 : m_cnt + 1;
      // shifter
      nd = 0;
      if (!en) begin m_busy = 0; m_sck = pol; m_edge = 0; end
      else if (!ob) begin
        m_sck = pol;
        if (wd) begin
          m_busy = 1; m_tx = b_wdata; m_edge = 0;
          if (!pha) m_mosi = pick(b_wdata, 0, lsb);
        end
      end else if (tk) begin
        int k;
        k = m_edge / 2;
        m_sck = !m_sck;
        if ((m_edge % 2) == int'(pha)) begin
          if (lsb) m_rx[k] = miso; else m_rx[7-k] = miso;
        end
        if (!pha && (m_edge % 2 == 1) && k != 7) m_mosi = pick(m_tx, k + 1, lsb);
        if (pha && (m_edge % 2 == 0)) m_mosi = pick(m_tx, k, lsb);
        if (m_edge == 15) begin m_busy = 0; nd = 1; end
        m_edge = (m_edge + 1) % 16;
      end
      // register writes
      if (b_wr) case (b_addr)
        5'h00: m_c1 = b_wdata;
        5'h01: m_c2 = b_wdata;
        5'h04: m_rate = b_wdata & 8'h77;
        5'h0D: m_pd = b_wdata;
        5'h10: m_pdir = b_wdata;
        default: ;
      endcase
      m_done = nd;
    end
  end

  // every-cycle comparison, a quarter period before the rising edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      logic [7:0] er;
      er = 0;
      if (b_rd) case (b_addr)
        5'h00: er = m_c1;
        5'h01: er = m_c2;
        5'h04: er = m_rate;
        5'h05: er = {m_spif, m_wcol, 1'b0, m_modf, 4'b0};
        5'h09: er = m_rxbuf;
        5'h0D: er = m_pd;
        5'h10: er = m_pdir;
        default: er = 0;
      endcase
      chk("R3 R4 sck", sck, m_sck);
      chk("R5 mosi", mosi, m_mosi);
      chk("R12 ss/oe", {ss_n, ss_oe, sck_oe, mosi_oe},
          {m_pd[3], m_pdir[3], m_pdir[2], m_pdir[1]});
      chk("R11 irq", irq, m_c1[7] & (m_spif | m_modf));
      chk("R2 R8 R9 R10 rdata", rdata, er);
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); b_addr = a; b_rd = 1'b1;
    #5 d = rdata;
    @(negedge clk); b_rd = 1'b0;
  endtask

  int cur_half = 1;
  task automatic set_rate(input logic [7:0] r);
    wr(5'h04, r);
    cur_half = (int'(r[6:4]) + 1) << r[2:0];
  endtask

  task automatic xfer(input logic [7:0] d);
    wr(5'h09, d);
    repeat (16 * cur_half + 4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sck", sck, 0);
    chk("R1 irq", irq, 0);
    foreach (v[i]) ;
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    rd(5'h04, v); chk("R1 rate", v, 0);
    rd(5'h05, v); chk("R1 status", v, 0);
    rd(5'h10, v); chk("R1 pdir", v, 0);
    // R2 readback and masking
    wr(5'h04, 8'hFF); rd(5'h04, v); chk("R2 rate mask", v, 8'h77);
    wr(5'h01, 8'h5A); rd(5'h01, v); chk("R2 ctrl2", v, 8'h5A);
    rd(5'h07, v); chk("R2 unused", v, 0);
    // R12 select and pad enables
    wr(5'h10, 8'h0E); wr(5'h0D, 8'h08);
    chk("R12 ss high", ss_n, 1);
    chk("R12 oes", {ss_oe, sck_oe, mosi_oe}, 3'b111);
    wr(5'h0D, 8'h00); chk("R12 ss low", ss_n, 0);
    // R6 write ignored when not master
    set_rate(8'h00);
    wr(5'h00, 8'h40); xfer(8'hC3);
    rd(5'h05, v); chk("R6 no start", v, 0);
    // R5 first bit on MOSI, MSB then LSB first
    wr(5'h00, 8'h50); wr(5'h09, 8'h80); chk("R5 msb first", mosi, 1);
    repeat (20) @(negedge clk);
    rd(5'h05, v); chk("R8 done set", v, 8'h80);
    rd(5'h09, v); rd(5'h05, v); chk("R8 cleared", v, 0);
    wr(5'h00, 8'h51); wr(5'h09, 8'h80); chk("R5 lsb first", mosi, 0);
    repeat (20) @(negedge clk);
    // R8 data read without status read does not clear
    rd(5'h09, v); rd(5'h05, v); chk("R8 sticky", v, 8'h80);
    rd(5'h09, v);
    // R3 R4 R5 all modes and rates, checked by the model every cycle
    for (int m = 0; m < 8; m++) begin
      wr(5'h00, 8'h50 | ((m & 4) ? 8'h08 : 0) | ((m & 2) ? 8'h04 : 0) | ((m & 1) ? 8'h01 : 0));
      set_rate(8'(((m % 4) << 4) | (m % 3)));
      xfer(8'(8'h3C + m * 37));
      rd(5'h05, v); rd(5'h09, v);
    end
    set_rate(8'h77); xfer(8'h96); rd(5'h05, v); rd(5'h09, v);
    // R7 R9 collision
    set_rate(8'h21); wr(5'h00, 8'h50);
    wr(5'h09, 8'hA5); wr(5'h09, 8'h5A);
    repeat (16 * cur_half + 4) @(negedge clk);
    rd(5'h05, v); chk("R7 coll+done", v, 8'hC0);
    rd(5'h09, v); rd(5'h05, v); chk("R9 cleared", v, 0);
    // R10 R11 mode fault
    wr(5'h10, 8'h06); wr(5'h00, 8'hD0);
    @(negedge clk); ss_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 irq fault", irq, 1);
    rd(5'h05, v); chk("R10 fault set", v, 8'h10);
    ss_in = 1'b1;
    wr(5'h00, 8'hD0); rd(5'h05, v); chk("R10 cleared", v, 0);
    chk("R11 irq low", irq, 0);
    // R11 completion interrupt
    set_rate(8'h00); xfer(8'h11);
    chk("R11 irq done", irq, 1);
    rd(5'h05, v); rd(5'h09, v);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule